// File: doc/BRIEF.md
# SPI Transfer Pause Controller

This block sits between the synchronized, oversampled pins of a serial peripheral port and the command engine behind it. A host can stop a transfer in the middle by pulling an active-low hold input low, and later resume it with no loss of state. While the transfer is stopped, the block masks clock and data-in activity, drops the data-out enable, and freezes its bit position. The command engine receives one-cycle strobes for the qualified rising and falling serial-clock edges, a masked data-in bit, an output-enable gate for the data-out driver, and the bit position within the current word.

A pause starts and ends only while the serial clock is low. A change on hold seen while the clock is high is deferred to the next falling edge of the clock. A pause is only recognized while chip select is low. Raising chip select ends a pause and cancels the transfer. The controller has four states, all stepped by the system clock. ST_IDLE means deselected. ST_RUN means the transfer is flowing. ST_ARMED means hold went low while the clock was high, so the pause waits for the next falling edge. ST_PAUSE means the transfer is frozen. The transitions are:

- IDLE to RUN on select.
- RUN to PAUSE when hold is low and the clock is low.
- RUN to ARMED when hold is low and the clock is high.
- ARMED to PAUSE when the clock goes low with hold still low.
- ARMED to RUN when hold returns high first.
- PAUSE to RUN when hold is high and the clock is low.
- Any state to IDLE on deselect.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset, and while chip select is high, sck_rise, sck_fall, so_oe, paused and bit_idx are all 0.
- R2: When chip select is high, hold_n low has no effect. After a select with hold_n high, paused stays 0 and transfers run.
- R3: While selected, hold_n low with sck sampled low sets paused in the next cycle. With sck high, paused stays 0 until a cycle in which sck is sampled low with hold_n still low, and it is set in the cycle after that one.
- R4: A pause ends only in a cycle where hold_n is high and sck is low, and paused clears in the next cycle. With hold_n high and sck high, paused stays 1.
- R5: No strobe is issued while paused. The sck edge on which a pause begins and the edge on which it ends produce no strobe.
- R6: bit_idx does not change during a pause. After the pause it continues from the same value.
- R7: so_oe is 1 only when selected, hold_n is high and the controller is in RUN or ARMED. It is 0 whenever hold_n is low, even before the pause begins.
- R8: si_out follows si in RUN and ARMED. In the other states it holds the last si value seen in an active state.
- R9: Raising chip select during a pause clears paused and resets bit_idx to 0 in the next cycle.
- R10: bit_idx counts qualified rising strobes modulo WORD_BITS (default 8), so it wraps from 7 to 0.
- R11: sck_rise is 1 in the cycle where sck is first sampled 1 after a 0, and sck_fall is 1 in the cycle where sck is first sampled 0 after a 1. This holds only when the controller is in RUN or ARMED both before and after that cycle, and the first cycle after a select never strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Synchronized chip select, active low |
| sck | input | 1 | Synchronized serial clock level |
| si | input | 1 | Synchronized serial data in |
| hold_n | input | 1 | Synchronized hold request, active low |
| sck_rise | output | 1 | Qualified rising-edge strobe |
| sck_fall | output | 1 | Qualified falling-edge strobe |
| si_out | output | 1 | Masked data-in bit |
| so_oe | output | 1 | Data-out enable gate |
| paused | output | 1 | Pause active |
| bit_idx | output | $clog2(WORD_BITS) | Bit position within the current word |

## Verification
Random stimulus mixes serial clock toggles, long and short hold pulses and rare deselects. Every cycle is compared with a bench model, which separates correct entry timing from entry that comes one edge early or late. Directed runs cover these cases:

- Hold asserted while deselected, which tells the select gating apart from a plain hold path.
- Hold falling and rising while the clock is high, which tells the deferred alignment apart from an immediate one.
- A deselect during a pause, which shows whether the abort clears the bit position.

Bit positions before and after a pause show whether any edge leaked through.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_ARMED = 2'd2,
        ST_PAUSE = 2'd3
    } hold_state_e;
endpackage

// File: rtl/spi_hold_edge.sv
module spi_hold_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    output logic rise_raw,
    output logic fall_raw
);
    logic sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck;
    end

    assign rise_raw = sck & ~sck_q;
    assign fall_raw = ~sck & sck_q;
endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
    import spi_hold_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic hold_n,
    input  logic sck,
    input  logic rise_raw,
    input  logic fall_raw,
    output logic sck_rise,
    output logic sck_fall,
    output logic so_oe,
    output logic paused,
    output logic active
);
    hold_state_e state_q, state_d;
    logic next_active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (cs_n) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_RUN;
                ST_RUN:   if (!hold_n) state_d = sck ? ST_ARMED : ST_PAUSE;
                ST_ARMED: if (hold_n) state_d = ST_RUN;
                          else if (!sck) state_d = ST_PAUSE;
                ST_PAUSE: if (hold_n && !sck) state_d = ST_RUN;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        active      = (state_q == ST_RUN) || (state_q == ST_ARMED);
        next_active = (state_d == ST_RUN) || (state_d == ST_ARMED);
        paused      = (state_q == ST_PAUSE);
        sck_rise    = !cs_n && active && next_active && rise_raw;
        sck_fall    = !cs_n && active && next_active && fall_raw;
        so_oe       = !cs_n && hold_n && active;
    end

    AST_NO_STROBE_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        paused |-> !sck_rise && !sck_fall); // R5
    AST_OE_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_n |-> !so_oe); // R7
    AST_ENTER_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_PAUSE && state_d == ST_PAUSE) |-> !sck && !hold_n); // R3
    AST_EXIT_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAUSE && state_d == ST_RUN) |-> !sck && hold_n); // R4
    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !paused && !active); // R9
endmodule

// File: rtl/spi_hold_pos.sv
module spi_hold_pos #(
    parameter int WORD_BITS = 8,
    parameter int CNT_W     = $clog2(WORD_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sck_rise,
    input  logic             active,
    input  logic             paused,
    input  logic             si,
    output logic [CNT_W-1:0] bit_idx,
    output logic             si_out
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_BITS - 1);
    logic si_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx <= '0;
            si_last <= 1'b0;
        end else begin
            if (cs_n)
                bit_idx <= '0;
            else if (sck_rise)
                bit_idx <= (bit_idx == LAST_BIT) ? '0 : bit_idx + 1'b1;
            if (active)
                si_last <= si;
        end
    end

    assign si_out = active ? si : si_last;

    AST_POS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && !cs_n) |=> $stable(bit_idx)); // R6
    AST_SI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && $past(paused)) |-> $stable(si_out)); // R8
    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_idx <= LAST_BIT); // R10
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl #(
    parameter int WORD_BITS = 8,
    parameter int CNT_W     = $clog2(WORD_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sck,
    input  logic             si,
    input  logic             hold_n,
    output logic             sck_rise,
    output logic             sck_fall,
    output logic             si_out,
    output logic             so_oe,
    output logic             paused,
    output logic [CNT_W-1:0] bit_idx
);
    logic rise_raw, fall_raw, active;

    spi_hold_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .rise_raw (rise_raw),
        .fall_raw (fall_raw)
    );

    spi_hold_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .hold_n   (hold_n),
        .sck      (sck),
        .rise_raw (rise_raw),
        .fall_raw (fall_raw),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .so_oe    (so_oe),
        .paused   (paused),
        .active   (active)
    );

    spi_hold_pos #(.WORD_BITS(WORD_BITS), .CNT_W(CNT_W)) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck_rise (sck_rise),
        .active   (active),
        .paused   (paused),
        .si       (si),
        .bit_idx  (bit_idx),
        .si_out   (si_out)
    );
endmodule

// File: tb/spi_hold_ctrl_bench.sv
module spi_hold_ctrl_bench;
    localparam int WB = 8;
    localparam int CW = $clog2(WB);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic sck_rise, sck_fall, si_out, so_oe, paused;
    logic [CW-1:0] bit_idx;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // bench model: 0 idle, 1 run, 2 armed, 3 pause
    int m_st = 0;
    bit m_sckp = 1'b0;
    int m_cnt = 0;
    bit m_silast = 1'b0;

    always #5 clk = ~clk;

    spi_hold_ctrl #(.WORD_BITS(WB)) u_spi_hold_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .si_out(si_out), .so_oe(so_oe),
        .paused(paused), .bit_idx(bit_idx)
    );

    function automatic bit is_act(int s);
        return (s == 1) || (s == 2);
    endfunction

    function automatic int next_st(int s, bit c, bit k, bit h);
        if (c) return 0;
        case (s)
            0: return 1;
            1: return !h ? (k ? 2 : 3) : 1;
            2: return h ? 1 : (!k ? 3 : 2);
            default: return (h && !k) ? 1 : 3;
        endcase
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(bit c, bit k, bit d, bit h);
        int nx;
        bit er, ef;
        @(negedge clk);
        cs_n = c; sck = k; si = d; hold_n = h;
        #1;
        nx = next_st(m_st, c, k, h);
        er = !c && is_act(m_st) && is_act(nx) && k && !m_sckp;
        ef = !c && is_act(m_st) && is_act(nx) && !k && m_sckp;
        chk(sck_rise == er, "R11/R5 sck_rise", sck_rise, er);
        chk(sck_fall == ef, "R11/R5 sck_fall", sck_fall, ef);
        chk(so_oe == (!c && h && is_act(m_st)), "R7 so_oe", so_oe, !c && h && is_act(m_st));
        chk(paused == (m_st == 3), "R3/R4 paused", paused, m_st == 3);
        chk(int'(bit_idx) == m_cnt, "R6/R10 bit_idx", bit_idx, m_cnt);
        chk(si_out == (is_act(m_st) ? d : m_silast), "R8 si_out", si_out, is_act(m_st) ? d : m_silast);
        if (is_act(m_st)) m_silast = d;
        if (c) m_cnt = 0;
        else if (er) m_cnt = (m_cnt + 1) % WB;
        m_st = nx;
        m_sckp = k;
        @(posedge clk);
        #1;
    endtask

    task automatic clocks(int n, bit d);
        for (int i = 0; i < n; i++) begin
            cyc(1'b0, 1'b1, d, 1'b1);
            cyc(1'b0, 1'b0, ~d, 1'b1);
        end
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int kept_idx;
        bit c, k, h;
        void'($urandom(32'd7331));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        chk(!sck_rise && !sck_fall && !so_oe && !paused && bit_idx == 0, "R1 reset outputs", paused, 0);
        // R2: hold low while deselected does nothing
        for (int i = 0; i < 6; i++) cyc(1'b1, i[0], 1'b1, 1'b0);
        chk(paused == 1'b0 && bit_idx == 0, "R2 deselected hold", paused, 0);
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        chk(paused == 1'b0, "R2 select unpaused", paused, 0);
        clocks(3, 1'b1);
        chk(int'(bit_idx) == 3, "R11 three rises", bit_idx, 3);
        // R3: hold falls with sck high, deferred to the next fall
        cyc(1'b0, 1'b1, 1'b0, 1'b1);
        cyc(1'b0, 1'b1, 1'b0, 1'b0);
        cyc(1'b0, 1'b1, 1'b0, 1'b0);
        chk(paused == 1'b0, "R3 deferred entry", paused, 0);
        cyc(1'b0, 1'b0, 1'b0, 1'b0);
        chk(paused == 1'b1, "R3 entry on fall", paused, 1);
        kept_idx = bit_idx;
        // R5/R6: clock toggling while paused
        for (int i = 0; i < 5; i++) begin
            cyc(1'b0, 1'b1, 1'b1, 1'b0);
            cyc(1'b0, 1'b0, 1'b0, 1'b0);
        end
        chk(int'(bit_idx) == kept_idx, "R6 frozen position", bit_idx, kept_idx);
        // R4: hold rises with sck high, stays paused
        cyc(1'b0, 1'b1, 1'b0, 1'b1);
        cyc(1'b0, 1'b1, 1'b0, 1'b1);
        chk(paused == 1'b1, "R4 deferred exit", paused, 1);
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        chk(paused == 1'b0, "R4 exit on sck low", paused, 0);
        clocks(1, 1'b0);
        chk(int'(bit_idx) == (kept_idx + 1) % WB, "R6 resumes position", bit_idx, (kept_idx + 1) % WB);
        // R3: hold falls with sck low, immediate
        cyc(1'b0, 1'b0, 1'b0, 1'b0);
        chk(paused == 1'b1, "R3 immediate entry", paused, 1);
        // R9: deselect during pause aborts
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        chk(paused == 1'b0 && bit_idx == 0, "R9 abort", bit_idx, 0);
        // R10: wrap
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        clocks(WB + 2, 1'b1);
        chk(int'(bit_idx) == 2, "R10 wrap", bit_idx, 2);
        // random phase
        c = 1'b0; k = 1'b0; h = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            c = ($urandom % 100) < 2;
            if ($urandom % 2) k = ~k;
            if (($urandom % 6) == 0) h = ~h;
            cyc(c, k, 1'($urandom), h);
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule